// File: doc/BRIEF.md
# Dual-Capture Timer with Overflow Lock

The block holds a 16-bit up-counter and two 16-bit holding pairs. Each pair is read over a byte-wide register port as a low byte and a high byte. A capture strobe on a channel copies the current count into that channel's pair. The pair then stays locked until software has read both of its bytes. If a second strobe arrives while the pair is still locked, the channel raises a sticky overflow bit and keeps the oldest unread value.

A mode bit gives the first pair one of two roles. In capture mode it is capture channel 1, and the counter runs over its full 16-bit range. In period mode software may write the pair, the counter wraps to zero after it reaches the stored value, and strobes on channel 1 are ignored. A run bit gates the counter.

Register map (3-bit address):

| Address | Content |
|---|---|
| 0 | control: bit0 run, bit1 mode (1 = capture, 0 = period), bit4 channel-1 overflow, bit5 channel-2 overflow |
| 1 | count, low byte |
| 2 | count, high byte |
| 3 | pair 1, low byte |
| 4 | pair 1, high byte |
| 5 | pair 2, low byte |
| 6 | pair 2, high byte |
| 7 | reads as 0 |

Addresses 1, 2, 5, 6 and 7 are read-only.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 6) reads 0.
- R2: While control bit0 (run) is 1 the count rises by one on every clock. While it is 0 the count holds. A write to the control register takes effect on the following clock.
- R3: A strobe on an unlocked channel copies the count of that cycle into the channel's pair (channel 2: addresses 5/6; channel 1 in capture mode: addresses 3/4). The pair then becomes locked.
- R4: A strobe on a locked channel sets that channel's overflow bit in the control register (bit4 for channel 1, bit5 for channel 2).
- R5: While a pair is locked, its value does not change, and further strobes on that channel are ignored.
- R6: A locked pair unlocks only after both its low and high byte have been read since it was captured, in either order. Reading the same byte repeatedly does not unlock it.
- R7: A strobe that arrives in the same cycle as the read that completes the unlock counts as arriving after the read. The new count is latched and no overflow is flagged.
- R8: With control bit1 = 0 (period mode) the pair at addresses 3/4 is writable. The count goes to 0 on the clock after it equals that value, and channel-1 strobes have no effect. In capture mode, writes to addresses 3/4 are ignored.
- R9: Writing 0 to an overflow bit of the control register clears it. Writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks a byte as read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cap_evt | input | 2 | Capture strobes, bit0 channel 1, bit1 channel 2 |

## Verification
Two functions of a capture channel can fall in the same cycle: the read that completes the unlock of a pair, and a new capture strobe. The bench provokes this in two ways. First, it reads the low byte of a pair together with a strobe just after an unlock, so the bench sees the old value and the pair is captured again. Second, it reads the remaining byte of a locked pair together with a strobe. In both cases the next read of the pair must show the count from the strobe cycle, and the overflow bit must stay unchanged.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int NCH = 2;
   localparam int AW  = 3;
   localparam logic [AW-1:0] A_CTRL  = 3'd0;
   localparam logic [AW-1:0] A_TMR_L = 3'd1;
   localparam logic [AW-1:0] A_TMR_H = 3'd2;
   localparam logic [AW-1:0] A_P1_L  = 3'd3;
   localparam logic [AW-1:0] A_P1_H  = 3'd4;
   localparam logic [AW-1:0] A_P2_L  = 3'd5;
   localparam logic [AW-1:0] A_P2_H  = 3'd6;
   localparam int CB_RUN  = 0;
   localparam int CB_MODE = 1;
   localparam int CB_OVF  = 4;
endpackage

// File: rtl/dct_timer.sv
module dct_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         wrap_en,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run) begin
         if (wrap_en && (cnt == limit))
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dct_capture.sv
module dct_capture #(
   parameter int W        = 16,
   parameter int BW       = 8,
   parameter bit WRITABLE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic          evt,
   input  logic [W-1:0]  tmr,
   input  logic          rd_lo,
   input  logic          rd_hi,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [BW-1:0] wdata,
   input  logic          ovf_clr,
   output logic [W-1:0]  val,
   output logic          full,
   output logic          ovf
);
   if (W != 2 * BW) begin : g_bad_width
      $error("dct_capture: W must be twice BW");
   end

   logic [1:0] seen_q;
   logic       release_now;
   logic       open_now;
   logic       take;

   // completing read is ordered ahead of a same-cycle strobe
   assign release_now = full & (seen_q[0] | rd_lo) & (seen_q[1] | rd_hi);
   assign open_now    = ~full | release_now;
   assign take        = cap_en & evt & open_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         seen_q <= 2'b00;
      end else if (!cap_en) begin
         full   <= 1'b0;
         seen_q <= 2'b00;
      end else if (take) begin
         full   <= 1'b1;
         seen_q <= 2'b00;
      end else if (release_now) begin
         full   <= 1'b0;
         seen_q <= 2'b00;
      end else begin
         seen_q <= seen_q | {rd_hi, rd_lo};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (cap_en && evt && !open_now)
         ovf <= 1'b1;
      else if (ovf_clr)
         ovf <= 1'b0;
   end

   if (WRITABLE) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val <= '0;
         else if (take)
            val <= tmr;
         else if (!cap_en) begin
            if (wr_lo) val[BW-1:0] <= wdata;
            if (wr_hi) val[W-1:BW] <= wdata;
         end
      end
   end else begin : g_ro
      logic unused_wr;
      assign unused_wr = ^{wr_lo, wr_hi, wdata};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val <= '0;
         else if (take)
            val <= tmr;
      end
   end
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [dct_pkg::AW-1:0]  addr,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [BYTE_W-1:0]       wdata,
   output logic [BYTE_W-1:0]       rdata,
   input  logic [dct_pkg::NCH-1:0] cap_evt
);
   import dct_pkg::*;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_cfg
      $error("dual_capture_timer: CNT_W must be twice BYTE_W");
   end
   if (BYTE_W <= CB_OVF + NCH) begin : g_bad_byte
      $error("dual_capture_timer: BYTE_W too small for control bits");
   end

   logic             run_q;
   logic             mode_q;
   logic [CNT_W-1:0] tmr;
   logic [CNT_W-1:0] cap_val [NCH];
   logic [NCH-1:0]   cap_full;
   logic [NCH-1:0]   cap_ovf;
   logic             ctrl_wr;

   assign ctrl_wr = wr_en && (addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (ctrl_wr) begin
         run_q  <= wdata[CB_RUN];
         mode_q <= wdata[CB_MODE];
      end
   end

   dct_timer #(.W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .wrap_en (~mode_q),
      .limit   (cap_val[0]),
      .cnt     (tmr)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [AW-1:0] LO = A_P1_L + AW'(2 * i);
      localparam logic [AW-1:0] HI = A_P1_H + AW'(2 * i);
      logic en;
      if (i == 0) begin : g_shared
         assign en = mode_q;
      end else begin : g_plain
         assign en = 1'b1;
      end
      dct_capture #(
         .W        (CNT_W),
         .BW       (BYTE_W),
         .WRITABLE (i == 0)
      ) u_cap (
         .clk     (clk),
         .rst_n   (rst_n),
         .cap_en  (en),
         .evt     (cap_evt[i]),
         .tmr     (tmr),
         .rd_lo   (rd_en && (addr == LO)),
         .rd_hi   (rd_en && (addr == HI)),
         .wr_lo   (wr_en && (addr == LO)),
         .wr_hi   (wr_en && (addr == HI)),
         .wdata   (wdata),
         .ovf_clr (ctrl_wr && !wdata[CB_OVF + i]),
         .val     (cap_val[i]),
         .full    (cap_full[i]),
         .ovf     (cap_ovf[i])
      );
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[CB_RUN]               = run_q;
            rdata[CB_MODE]              = mode_q;
            rdata[CB_OVF +: NCH]        = cap_ovf;
         end
         A_TMR_L: rdata = tmr[BYTE_W-1:0];
         A_TMR_H: rdata = tmr[CNT_W-1:BYTE_W];
         A_P1_L:  rdata = cap_val[0][BYTE_W-1:0];
         A_P1_H:  rdata = cap_val[0][CNT_W-1:BYTE_W];
         A_P2_L:  rdata = cap_val[1][BYTE_W-1:0];
         A_P2_H:  rdata = cap_val[1][CNT_W-1:BYTE_W];
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
   parameter int W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run,
   input logic                    mode,
   input logic [W-1:0]            tmr,
   input logic [W-1:0]            period,
   input logic [W-1:0]            val2,
   input logic [dct_pkg::NCH-1:0] evt,
   input logic [dct_pkg::NCH-1:0] full,
   input logic [dct_pkg::NCH-1:0] ovf,
   input logic                    rd_en,
   input logic [dct_pkg::AW-1:0]  addr
);
   import dct_pkg::*;

   // R2
   tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tmr));

   // R2
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode) |=> (tmr == W'($past(tmr) + 1'b1)));

   // R8
   period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !mode && (tmr == period)) |=> (tmr == '0));

   // R3
   cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[1]) |-> (val2 == $past(tmr)));

   // R5
   cap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full[1] && !(rd_en && ((addr == A_P2_L) || (addr == A_P2_H))))
      |=> $stable(val2));

   // R4
   ovf2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[1]) |-> $past(evt[1] && full[1]));

   // R4
   ovf1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[0]) |-> $past(evt[0] && full[0] && mode));
endmodule

bind dual_capture_timer dct_chk #(.W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (run_q),
   .mode   (mode_q),
   .tmr    (tmr),
   .period (cap_val[0]),
   .val2   (cap_val[1]),
   .evt    (cap_evt),
   .full   (cap_full),
   .ovf    (cap_ovf),
   .rd_en  (rd_en),
   .addr   (addr)
);

// File: tb/tb_dual_capture_timer.sv
`timescale 1ns/1ps
module tb_dual_capture_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] cap_evt = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dual_capture_timer dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .cap_evt(cap_evt)
   );

   // entry: {rd, wr, evt1, evt2} addr data(write value or expected read) req
   localparam int NV = 45;
   localparam logic [18:0] VEC [NV] = '{
      {4'b0100, 3'd0, 8'h03, 4'd2},  // R2 start, capture mode
      {4'b1000, 3'd1, 8'h00, 4'd2},  // R2
      {4'b1000, 3'd1, 8'h01, 4'd2},  // R2
      {4'b0001, 3'd0, 8'h00, 4'd3},  // R3 capture count 2
      {4'b1000, 3'd5, 8'h02, 4'd3},  // R3
      {4'b0001, 3'd0, 8'h00, 4'd4},  // R4 strobe while locked
      {4'b1000, 3'd0, 8'h23, 4'd4},  // R4 bit5 set
      {4'b1000, 3'd5, 8'h02, 4'd5},  // R5 oldest kept
      {4'b0001, 3'd0, 8'h00, 4'd5},  // R5 ignored
      {4'b1000, 3'd6, 8'h00, 4'd6},  // R6 second byte unlocks
      {4'b0001, 3'd0, 8'h00, 4'd6},  // R6 capture 9
      {4'b1000, 3'd5, 8'h09, 4'd6},  // R6
      {4'b1000, 3'd6, 8'h00, 4'd6},  // R6 unlock
      {4'b1001, 3'd5, 8'h09, 4'd7},  // R7 low read with strobe, capture 12
      {4'b1000, 3'd6, 8'h00, 4'd6},  // R6 one byte only
      {4'b1001, 3'd5, 8'h0C, 4'd7},  // R7 final read with strobe, capture 14
      {4'b1000, 3'd5, 8'h0E, 4'd7},  // R7
      {4'b1000, 3'd0, 8'h23, 4'd7},  // R7 no new overflow
      {4'b0100, 3'd0, 8'h23, 4'd9},  // R9 write 1 keeps
      {4'b1000, 3'd0, 8'h23, 4'd9},  // R9
      {4'b0100, 3'd0, 8'h03, 4'd9},  // R9 write 0 clears
      {4'b1000, 3'd0, 8'h03, 4'd9},  // R9
      {4'b0010, 3'd0, 8'h00, 4'd3},  // R3 channel 1 capture 21
      {4'b1000, 3'd3, 8'h15, 4'd3},  // R3
      {4'b1000, 3'd4, 8'h00, 4'd3},  // R3
      {4'b0100, 3'd0, 8'h02, 4'd2},  // R2 stop
      {4'b1000, 3'd1, 8'h19, 4'd2},  // R2
      {4'b1000, 3'd1, 8'h19, 4'd2},  // R2 held
      {4'b0100, 3'd3, 8'h05, 4'd8},  // R8 write in capture mode
      {4'b1000, 3'd3, 8'h15, 4'd8},  // R8 ignored
      {4'b0100, 3'd0, 8'h00, 4'd8},  // R8 period mode
      {4'b0100, 3'd3, 8'h1C, 4'd8},  // R8 period 28
      {4'b0100, 3'd4, 8'h00, 4'd8},  // R8
      {4'b0100, 3'd0, 8'h01, 4'd8},  // R8 run
      {4'b1000, 3'd1, 8'h19, 4'd8},  // R8
      {4'b0000, 3'd0, 8'h00, 4'd8},  // R8
      {4'b0010, 3'd0, 8'h00, 4'd8},  // R8 channel 1 strobe ignored
      {4'b1000, 3'd1, 8'h1C, 4'd8},  // R8 at period
      {4'b1000, 3'd1, 8'h00, 4'd8},  // R8 wrapped
      {4'b1000, 3'd1, 8'h01, 4'd8},  // R8
      {4'b1000, 3'd3, 8'h1C, 4'd8},  // R8 period intact
      {4'b0100, 3'd0, 8'h03, 4'd4},  // R4 capture mode
      {4'b0010, 3'd0, 8'h00, 4'd4},  // R4
      {4'b0010, 3'd0, 8'h00, 4'd4},  // R4 channel 1 overflow
      {4'b1000, 3'd0, 8'h13, 4'd4}   // R4 bit4 set
   };

   task automatic check(input logic [7:0] exp, input int req, input string what);
      n_chk++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, rdata, exp);
      end
   endtask

   task automatic step(input logic [18:0] v);
      @(negedge clk);
      rd_en   = v[18];
      wr_en   = v[17];
      cap_evt = {v[15], v[16]};
      addr    = v[14:12];
      wdata   = v[11:4];
      #1;
      if (v[18]) check(v[11:4], int'(v[3:0]), $sformatf("addr %0d", v[14:12]));
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; cap_evt = '0; addr = '0; wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      // R1 reset state of every register, read without strobing
      for (int a = 0; a < 7; a++) begin
         @(negedge clk);
         addr = 3'(a);
         #1;
         check(8'h00, 1, $sformatf("reset addr %0d", a));
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) step(VEC[i]);
      idle();
      // R1 reset again mid-run
      rst_n = 1'b0;
      #1;
      addr = 3'd0;
      #1;
      check(8'h00, 1, "reset ctrl");
      addr = 3'd5;
      #1;
      check(8'h00, 1, "reset pair2 lo");
      @(negedge clk);
      rst_n = 1'b1;
      addr = 3'd1;
      #1;
      check(8'h00, 1, "reset count");
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule